// File: doc/BRIEF.md
# Shared-Pin Fault Break Controller

This block is the fault-protection stage of a PWM timer. It gathers several kinds of break request into one latched break event: a clock-failure alarm, a vector of on-chip peripheral fault lines, a software break strobe, and the level seen on one shared board-level break pin. On any break it drops the main output enable, which puts the PWM outputs in their safe state, and it sets a sticky break flag.

The shared pin is both an input and an open-drain, active-low fault output. When bidirectional mode is selected and the pin polarity is active low, a latched fault pulls the pin low. This tells other devices on the same line that this timer has tripped. With active-high polarity the driver stays off. The software break strobe drives the pin only while break input is enabled. Without break enable, the strobe still trips the outputs and sets the flag.

Pulling its own pin low would keep the block in break for ever. A disarm bit prevents this. Protection is disarmed only while the main output enable is 0, bidirectional mode is on and disarm is set. In that state the pin driver is released and the external line can recover. The pin input path stays live at all times. Software re-arms the block with a re-arm strobe, which clears the disarm bit only once the synchronized pin reads high.

Top module: `brk_fault_ctrl`

## Requirements
- R1: After reset the outputs read as follows: `moe_o`=0, `brk_flag_o`=0, `pin_oe_o`=0, `disarm_o`=0, `bidir_o`=0 and `armed_o`=1.
- R2: Each of the following raises `brk_flag_o` and clears `moe_o`:
  - `sys_alarm_i`;
  - any bit of `periph_fault_i`;
  - `sw_brk_i`;
  - an active pin level while `brk_en_i`=1. The active level is low when `pol_high_i`=0 and high when `pol_high_i`=1.

  The flag holds until `flag_clr_i`. A break in the same cycle as the clear wins.
- R3: `moe_set_i` sets `moe_o` only in a cycle with no break request. Otherwise it is ignored.
- R4: `bidir_wr_i` loads `bidir_val_i` into `bidir_o` only when `lock_lvl_i`=0. At lock level 1 to 3 the write is ignored.
- R5: With `bidir_o`=1 and `pol_high_i`=0, the following latch a fault that holds `pin_oe_o`=1, so the modelled pin stays low:
  - an alarm;
  - a peripheral fault;
  - an enabled pin break.
- R6: With `pol_high_i`=1, `pin_oe_o` is never asserted.
- R7: `sw_brk_i` drives the pin (R5 conditions) only when `brk_en_i`=1. With `brk_en_i`=0 it still trips the flag and `moe_o`, and `pin_oe_o` stays 0.
- R8: `armed_o` is 0 exactly when `moe_o`=0, `bidir_o`=1 and `disarm_o`=1. While disarmed, `pin_oe_o`=0 and the fault latch clears. A later `moe_set_i` re-arms protection.
- R9: While disarmed, an active pin level still raises `brk_flag_o` and holds `moe_o` at 0.
- R10: `disarm_set_i` sets `disarm_o`. `rearm_i` clears it only when the synchronized pin is high, and is ignored while the pin is low.
- R11: The pin passes through SYNC_STAGES (default 2) flops, reset high. A pin break therefore reaches `brk_flag_o` at the third rising edge after the pin changes, and not at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lock_lvl_i | input | 2 | Configuration lock level, 0 = unlocked |
| bidir_wr_i | input | 1 | Write strobe for the bidirectional-mode bit |
| bidir_val_i | input | 1 | Value written to the bidirectional-mode bit |
| brk_en_i | input | 1 | Break input enable |
| pol_high_i | input | 1 | Pin polarity, 1 = active high, 0 = active low |
| sys_alarm_i | input | 1 | Clock-failure alarm |
| periph_fault_i | input | N_PERIPH | On-chip peripheral fault requests |
| sw_brk_i | input | 1 | Software break strobe |
| moe_set_i | input | 1 | Software request to enable the main outputs |
| flag_clr_i | input | 1 | Clear strobe for the break flag |
| disarm_set_i | input | 1 | Set strobe for the disarm bit |
| rearm_i | input | 1 | Re-arm request, clears the disarm bit when the pin is high |
| pin_i | input | 1 | Shared break pin input sample |
| pin_oe_o | output | 1 | Open-drain enable, 1 pulls the pin low |
| moe_o | output | 1 | Main output enable |
| brk_flag_o | output | 1 | Sticky break flag |
| disarm_o | output | 1 | Disarm bit |
| bidir_o | output | 1 | Bidirectional-mode bit |
| armed_o | output | 1 | Break protection armed |

## Verification
The fault latch is the only internal state that cannot be read directly. It is observed through `pin_oe_o` in the cycle after the latch is set. With the pin modelled as a wired-AND with a pull-up, a stuck-set latch also shows up as a break that keeps coming back three edges after every flag clear.

A wrong synchronizer depth moves the edge on which a pin break first appears on `brk_flag_o`. A disarm or re-arm fault shows on `armed_o` and `pin_oe_o` in the same cycle.

// File: rtl/brk_pkg.sv
package brk_pkg;
   localparam int LOCK_W = 2;

   typedef enum logic [LOCK_W-1:0] {
      LOCK_OFF = 2'd0,
      LOCK_L1  = 2'd1,
      LOCK_L2  = 2'd2,
      LOCK_L3  = 2'd3
   } lock_lvl_e;

   typedef struct packed {
      logic hw_src;
      logic pin_brk;
      logic sw_src;
      logic drive_src;
   } brk_req_t;
endpackage

// File: rtl/brk_sync.sv
module brk_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("brk_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/brk_req_merge.sv
module brk_req_merge
   import brk_pkg::*;
#(
   parameter int N_PERIPH = 4
) (
   input  logic                brk_en_i,
   input  logic                pol_high_i,
   input  logic                sys_alarm_i,
   input  logic [N_PERIPH-1:0] periph_fault_i,
   input  logic                sw_brk_i,
   input  logic                pin_sync_i,
   output brk_req_t            req_o
);
   logic periph_any;

   generate
      if (N_PERIPH == 1) begin : g_one
         assign periph_any = periph_fault_i[0];
      end else begin : g_many
         assign periph_any = |periph_fault_i;
      end
   endgenerate

   always_comb begin
      req_o.hw_src    = sys_alarm_i | periph_any;
      req_o.pin_brk   = brk_en_i & (pol_high_i ? pin_sync_i : ~pin_sync_i);
      req_o.sw_src    = sw_brk_i;
      req_o.drive_src = req_o.hw_src | req_o.pin_brk | (sw_brk_i & brk_en_i);
   end
endmodule

// File: rtl/brk_state.sv
module brk_state
   import brk_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [LOCK_W-1:0] lock_lvl_i,
   input  logic              bidir_wr_i,
   input  logic              bidir_val_i,
   input  logic              pol_high_i,
   input  brk_req_t          req_i,
   input  logic              moe_set_i,
   input  logic              flag_clr_i,
   input  logic              disarm_set_i,
   input  logic              rearm_i,
   input  logic              pin_sync_i,
   output logic              moe_o,
   output logic              flag_o,
   output logic              fault_o,
   output logic              disarm_o,
   output logic              bidir_o,
   output logic              disarmed_o
);
   logic any_brk, drive_ok, unlocked;

   assign unlocked   = (lock_lvl_e'(lock_lvl_i) == LOCK_OFF);
   assign any_brk    = req_i.hw_src | req_i.pin_brk | req_i.sw_src;
   assign drive_ok   = bidir_o & ~pol_high_i;
   assign disarmed_o = ~moe_o & bidir_o & disarm_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         moe_o    <= 1'b0;
         flag_o   <= 1'b0;
         fault_o  <= 1'b0;
         disarm_o <= 1'b0;
         bidir_o  <= 1'b0;
      end else begin
         if (any_brk)        moe_o <= 1'b0;
         else if (moe_set_i) moe_o <= 1'b1;

         if (any_brk)         flag_o <= 1'b1;
         else if (flag_clr_i) flag_o <= 1'b0;

         if (disarmed_o || !drive_ok) fault_o <= 1'b0;
         else if (req_i.drive_src)    fault_o <= 1'b1;

         if (disarm_set_i)             disarm_o <= 1'b1;
         else if (rearm_i && pin_sync_i) disarm_o <= 1'b0;

         if (bidir_wr_i && unlocked) bidir_o <= bidir_val_i;
      end
   end
endmodule

// File: rtl/brk_fault_ctrl.sv
module brk_fault_ctrl
   import brk_pkg::*;
#(
   parameter int N_PERIPH    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [LOCK_W-1:0]   lock_lvl_i,
   input  logic                bidir_wr_i,
   input  logic                bidir_val_i,
   input  logic                brk_en_i,
   input  logic                pol_high_i,
   input  logic                sys_alarm_i,
   input  logic [N_PERIPH-1:0] periph_fault_i,
   input  logic                sw_brk_i,
   input  logic                moe_set_i,
   input  logic                flag_clr_i,
   input  logic                disarm_set_i,
   input  logic                rearm_i,
   input  logic                pin_i,
   output logic                pin_oe_o,
   output logic                moe_o,
   output logic                brk_flag_o,
   output logic                disarm_o,
   output logic                bidir_o,
   output logic                armed_o
);
   generate
      if (N_PERIPH < 1) begin : g_bad_np
         $error("brk_fault_ctrl: N_PERIPH must be at least 1");
      end
   endgenerate

   logic     pin_sync, fault_q, disarmed;
   brk_req_t req;

   brk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i (clk_i), .rst_ni (rst_ni), .d_i (pin_i), .q_o (pin_sync)
   );

   brk_req_merge #(.N_PERIPH(N_PERIPH)) u_merge (
      .brk_en_i       (brk_en_i),
      .pol_high_i     (pol_high_i),
      .sys_alarm_i    (sys_alarm_i),
      .periph_fault_i (periph_fault_i),
      .sw_brk_i       (sw_brk_i),
      .pin_sync_i     (pin_sync),
      .req_o          (req)
   );

   brk_state u_state (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .lock_lvl_i   (lock_lvl_i),
      .bidir_wr_i   (bidir_wr_i),
      .bidir_val_i  (bidir_val_i),
      .pol_high_i   (pol_high_i),
      .req_i        (req),
      .moe_set_i    (moe_set_i),
      .flag_clr_i   (flag_clr_i),
      .disarm_set_i (disarm_set_i),
      .rearm_i      (rearm_i),
      .pin_sync_i   (pin_sync),
      .moe_o        (moe_o),
      .flag_o       (brk_flag_o),
      .fault_o      (fault_q),
      .disarm_o     (disarm_o),
      .bidir_o      (bidir_o),
      .disarmed_o   (disarmed)
   );

   assign pin_oe_o = fault_q & ~disarmed & bidir_o & ~pol_high_i;
   assign armed_o  = ~disarmed;
endmodule

// File: rtl/brk_fault_ctrl_chk.sv
module brk_fault_ctrl_chk #(
   parameter int N_PERIPH = 4
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic [1:0]          lock_lvl_i,
   input logic                bidir_wr_i,
   input logic                sys_alarm_i,
   input logic [N_PERIPH-1:0] periph_fault_i,
   input logic                flag_clr_i,
   input logic                disarm_set_i,
   input logic                rearm_i,
   input logic                pol_high_i,
   input logic                pin_oe_o,
   input logic                moe_o,
   input logic                brk_flag_o,
   input logic                disarm_o,
   input logic                bidir_o,
   input logic                armed_o
);
   p_hw_trips_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sys_alarm_i || (|periph_fault_i)) |=> (!moe_o && brk_flag_o));

   p_flag_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (brk_flag_o && !flag_clr_i) |=> brk_flag_o);

   p_moe_blocked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sys_alarm_i |=> !moe_o);

   p_bidir_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_lvl_i != 2'd0 || !bidir_wr_i) |=> $stable(bidir_o));

   p_no_drive_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pol_high_i |-> !pin_oe_o);

   p_disarm_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!armed_o) |-> (!pin_oe_o && !moe_o && bidir_o && disarm_o));

   p_disarm_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (disarm_o && !rearm_i) |=> disarm_o);

   p_disarm_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disarm_set_i |=> disarm_o);
endmodule

bind brk_fault_ctrl brk_fault_ctrl_chk #(.N_PERIPH(N_PERIPH)) u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .lock_lvl_i     (lock_lvl_i),
   .bidir_wr_i     (bidir_wr_i),
   .sys_alarm_i    (sys_alarm_i),
   .periph_fault_i (periph_fault_i),
   .flag_clr_i     (flag_clr_i),
   .disarm_set_i   (disarm_set_i),
   .rearm_i        (rearm_i),
   .pol_high_i     (pol_high_i),
   .pin_oe_o       (pin_oe_o),
   .moe_o          (moe_o),
   .brk_flag_o     (brk_flag_o),
   .disarm_o       (disarm_o),
   .bidir_o        (bidir_o),
   .armed_o        (armed_o)
);

// File: tb/brk_fault_ctrl_tb_top.sv
module brk_fault_ctrl_tb_top;
   localparam int NP = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] lock_lvl = 2'd0;
   logic bidir_wr = 0, bidir_val = 0, brk_en = 0, pol_high = 0;
   logic sys_alarm = 0, sw_brk = 0, moe_set = 0, flag_clr = 0;
   logic disarm_set = 0, rearm = 0, ext_act = 0;
   logic [NP-1:0] periph = '0;
   logic pin, pin_oe, moe, flag, disarm, bidir, armed;
   int   checks = 0, fails = 0;
   bit   done = 0;

   always #2.5 clk = ~clk;

   // Pin model: active-low wired-AND line with pull-up, or active-high line driven by the bench.
   assign pin = pol_high ? ext_act : ~(pin_oe | ext_act);

   brk_fault_ctrl #(.N_PERIPH(NP), .SYNC_STAGES(2)) dut_i (
      .clk_i (clk), .rst_ni (rst_n), .lock_lvl_i (lock_lvl),
      .bidir_wr_i (bidir_wr), .bidir_val_i (bidir_val), .brk_en_i (brk_en),
      .pol_high_i (pol_high), .sys_alarm_i (sys_alarm), .periph_fault_i (periph),
      .sw_brk_i (sw_brk), .moe_set_i (moe_set), .flag_clr_i (flag_clr),
      .disarm_set_i (disarm_set), .rearm_i (rearm), .pin_i (pin),
      .pin_oe_o (pin_oe), .moe_o (moe), .brk_flag_o (flag), .disarm_o (disarm),
      .bidir_o (bidir), .armed_o (armed)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 0; lock_lvl = 0; bidir_wr = 0; bidir_val = 0; brk_en = 0; pol_high = 0;
      sys_alarm = 0; sw_brk = 0; moe_set = 0; flag_clr = 0; disarm_set = 0;
      rearm = 0; ext_act = 0; periph = '0;
      cyc(2);
      rst_n = 1;
      cyc(1);
   endtask

   task automatic set_bidir(input logic v);
      bidir_wr = 1; bidir_val = v; cyc(1); bidir_wr = 0;
   endtask

   task automatic pulse_moe();
      moe_set = 1; cyc(1); moe_set = 0;
   endtask

   initial begin
      #200000;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1", "moe", moe, 0);
      chk("R1", "flag", flag, 0);
      chk("R1", "oe", pin_oe, 0);
      chk("R1", "disarm", disarm, 0);
      chk("R1", "bidir", bidir, 0);
      chk("R1", "armed", armed, 1);

      // R4 lock
      for (int l = 1; l < 4; l++) begin
         lock_lvl = 2'(l); set_bidir(1);
         chk("R4", "locked write ignored", bidir, 0);
      end
      lock_lvl = 0; set_bidir(1);
      chk("R4", "unlocked write", bidir, 1);

      // Sweep: R2 R5 R6 R7 over polarity, break enable, mode and source
      for (int c = 0; c < 32; c++) begin
         automatic logic p   = c[0];
         automatic logic be  = c[1];
         automatic logic bd  = c[2];
         automatic int   src = c / 8;
         automatic logic e_flag, e_oe;
         do_reset();
         pol_high = p; brk_en = be;
         set_bidir(bd);
         cyc(3);
         pulse_moe();
         chk("R3", "moe set when idle", moe, 1);
         case (src)
            0: sys_alarm = 1;
            1: periph = NP'(1) << (c % NP);
            2: sw_brk = 1;
            default: ext_act = 1;
         endcase
         cyc(1);
         sys_alarm = 0; periph = '0; sw_brk = 0; ext_act = 0;
         cyc(4);
         e_flag = (src == 3) ? be : 1'b1;
         case (src)
            0, 1:    e_oe = bd & ~p;
            2:       e_oe = bd & ~p & be;   // R7
            default: e_oe = bd & ~p & be;
         endcase
         chk("R2", "flag", flag, e_flag);
         chk("R2", "moe", moe, ~e_flag);
         chk(p ? "R6" : (src == 2 ? "R7" : "R5"), "pin_oe", pin_oe, e_oe);
      end

      // R11 pin synchronizer latency
      do_reset();
      brk_en = 1;
      ext_act = 1; cyc(2);
      chk("R11", "flag after two edges", flag, 0);
      cyc(1);
      chk("R11", "flag after three edges", flag, 1);
      ext_act = 0; cyc(3);

      // R2 flag hold and set-wins-over-clear
      do_reset();
      sys_alarm = 1; cyc(1); sys_alarm = 0; cyc(3);
      chk("R2", "flag held", flag, 1);
      sys_alarm = 1; flag_clr = 1; cyc(1); sys_alarm = 0; flag_clr = 0;
      chk("R2", "set wins over clear", flag, 1);
      flag_clr = 1; cyc(1); flag_clr = 0;
      chk("R2", "flag cleared", flag, 0);

      // R3 moe_set blocked during break
      sys_alarm = 1; moe_set = 1; cyc(1);
      chk("R3", "moe blocked", moe, 0);
      sys_alarm = 0; cyc(1); moe_set = 0;
      chk("R3", "moe after break gone", moe, 1);

      // R8 R9 R10 disarm / re-arm
      do_reset();
      brk_en = 1; set_bidir(1); cyc(3); pulse_moe();
      sys_alarm = 1; cyc(1); sys_alarm = 0; cyc(4);
      chk("R5", "self-held drive", pin_oe, 1);
      chk("R8", "armed while driving", armed, 1);
      disarm_set = 1; cyc(1); disarm_set = 0;
      chk("R8", "armed when disarmed", armed, 0);
      chk("R8", "oe released", pin_oe, 0);
      cyc(4);
      flag_clr = 1; cyc(1); flag_clr = 0; cyc(1);
      chk("R8", "line recovered, flag stays clear", flag, 0);
      ext_act = 1; cyc(4);
      chk("R9", "pin still breaks", flag, 1);
      chk("R9", "moe held off", moe, 0);
      chk("R8", "no drive while disarmed", pin_oe, 0);
      rearm = 1; cyc(1); rearm = 0;
      chk("R10", "rearm ignored while pin low", disarm, 1);
      ext_act = 0; cyc(3);
      pulse_moe();
      chk("R8", "moe set re-arms", armed, 1);
      chk("R8", "disarm bit kept", disarm, 1);
      rearm = 1; cyc(1); rearm = 0;
      chk("R10", "rearm clears disarm", disarm, 0);
      chk("R10", "armed", armed, 1);
      chk("R10", "no drive after rearm", pin_oe, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule